// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects eight interrupt request lines, weighs them against a mask register, an in-service register and a rotating priority order, and raises a single interrupt output toward a processor. The processor answers with two acknowledge pulses. The first pulse picks the winning level and marks it as in service. The second pulse returns an 8-bit vector made of a fixed 5-bit base and the 3-bit level number.

Software controls the block through a write port with a one-bit address and a data byte. Three command words are decoded: a mask write, an end-of-interrupt and priority command, and a mode command. The mode command switches special mask mode and chooses which register a read returns. A read port with the same address bit returns the mask register (address 1), or either the request register or the in-service register (address 0). Reset values take the place of an initialisation sequence. After reset the order is fixed, with level 0 highest and level 7 lowest, all levels are unmasked, nothing is in service, and reads at address 0 return the request register. A strap input turns automatic end of interrupt on or off.

Top module: `pic8_core`

## Requirements
- R1: A write with `reg_sel`=1 loads `wr_data` into the mask register. Bit n set to 1 inhibits level n. A read with `reg_sel`=1 returns the mask register.
- R2: After reset the mask and in-service registers are zero, `irq_out` is low, `vec_valid` is low, the lowest-priority level is 7, and a read with `reg_sel`=0 returns the request register.
- R3: The request register samples `irq_in` every cycle. With nothing in service, `irq_out` is high when an unmasked request is pending. The winner is the pending unmasked request of highest priority, and a masked request never wins.
- R4: The first `ack` pulse sets the in-service bit of the winner. The second `ack` pulse makes `vec_valid` high for exactly one cycle, with `vec_out` = {VEC_BASE, level}.
- R5: In normal mask mode, an in-service bit holds off requests of the same or lower priority. A request of strictly higher priority still raises `irq_out`.
- R6: A write with `reg_sel`=0 and data bits [7:5]=001, [4:3]=00 (non-specific end of interrupt) clears the in-service bit of highest priority.
- R7: Data bits [7:5]=011, [4:3]=00 (specific end of interrupt) clears the in-service bit of the level in data bits [2:0].
- R8: Data bits [7:5]=101, [4:3]=00 clear the highest-priority in-service bit and make that level the lowest priority. Bits [7:5]=111 clear the bit of level [2:0] and make that level the lowest priority.
- R9: Data bits [7:5]=110, [4:3]=00 make level [2:0] the lowest priority and leave the in-service register unchanged.
- R10: In the mode word (`reg_sel`=0, bit 7=0, bits [4:3]=01), bit 6=1 lets bit 5 set special mask mode (bit 5=1) or clear it (bit 5=0). With bit 6=0 the mask mode is unchanged. In special mask mode a level is held off only by its own mask or in-service bit.
- R11: With `auto_eoi_en`=1, the second `ack` pulse clears the in-service bit that the first pulse set.
- R12: In the mode word, bit 1=1 selects the read source for `reg_sel`=0, with bit 0=1 selecting the in-service register and bit 0=0 the request register. Bit 1=0 leaves the selection unchanged.
- R13: If no request qualifies at the first `ack` pulse, no in-service bit is set and the vector carries level 7.
- R14: A write with `reg_sel`=0 and data bit 4=1, or with bits [4:3]=01 and bit 7=1, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Address bit for reads and writes |
| wr_en | input | 1 | Write strobe, one cycle per command |
| wr_data | input | 8 | Command or mask byte |
| rd_data | output | 8 | Register selected by `reg_sel` and the read source |
| irq_in | input | 8 | Level-sensitive interrupt request lines |
| auto_eoi_en | input | 1 | Strap that enables automatic end of interrupt |
| ack | input | 1 | Acknowledge pulse, two per interrupt |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | One-cycle strobe that qualifies `vec_out` |
| vec_out | output | 8 | Vector: base in bits [7:3], level in bits [2:0] |

## Verification
The bench targets the point where nesting blocks a request: a lower level pending under an active in-service bit must leave `irq_out` low in normal mode and raise it in special mask mode. A resolver that ignores the in-service register, or applies it in both modes, fails both checks. Rotation is tested with requests that a fixed order would resolve the other way. The tests cover the serviced level becoming lowest priority, the set-priority command, and the specific rotate command, so a pointer that is not updated, or updated off by one, returns the wrong vector. Command words with invalid decode bits, a mode word with its enable bits clear, and an acknowledge with no request pending (which must return level 7 and leave the in-service register empty) catch decoders that are too loose and sequencers that set a bit they should not.

// File: rtl/pic8_pkg.sv
// Package: pic8_pkg
// Shared widths, command encodings and priority helpers for the eight-input
// interrupt controller. Assumes a level count that is a power of two, so that
// level arithmetic wraps naturally in LVL_W bits.
package pic8_pkg;

    localparam int LVL_W   = 3;
    localparam int NUM_LVL = 1 << LVL_W;
    localparam int DATA_W  = 8;
    localparam int BASE_W  = DATA_W - LVL_W;

    typedef logic [LVL_W-1:0] lvl_t;

    // Decoded end-of-interrupt / priority command.
    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_EOI_NS  = 3'd1,
        CMD_EOI_SP  = 3'd2,
        CMD_ROT_NS  = 3'd3,
        CMD_ROT_SP  = 3'd4,
        CMD_SET_PRI = 3'd5
    } eoi_cmd_e;

    // Everything one write can ask of the register file.
    typedef struct packed {
        logic              mask_we;
        logic [DATA_W-1:0] mask_val;
        eoi_cmd_e          eoi_cmd;
        lvl_t              eoi_lvl;
        logic              mode_we;
        logic              smm_we;
        logic              smm_val;
        logic              rsel_we;
        logic              rsel_val;
    } cmd_t;

    // Rank of a level given the current lowest-priority level (0 = highest).
    function automatic lvl_t rank_of(lvl_t lvl, lvl_t low);
        return lvl_t'(lvl - low - lvl_t'(1));
    endfunction

    // Highest-priority set bit of vec; returns {found, level}.
    function automatic logic [LVL_W:0] pick_top(logic [NUM_LVL-1:0] vec, lvl_t low);
        logic found;
        lvl_t sel;
        found = 1'b0;
        sel   = '0;
        for (int k = 0; k < NUM_LVL; k++) begin
            lvl_t idx;
            idx = lvl_t'(low + lvl_t'(k) + lvl_t'(1));
            if (!found && vec[idx]) begin
                found = 1'b1;
                sel   = idx;
            end
        end
        return {found, sel};
    endfunction

endpackage

// File: rtl/pic8_cmd_decode.sv
// Module: pic8_cmd_decode
// Turns one register write into a set of strobes for the register file.
// Purely combinational. Assumes wr_en is asserted for one cycle per command.
// Words with invalid decode bits produce no strobe at all.
module pic8_cmd_decode
    import pic8_pkg::*;
(
    input  logic              wr_en,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    output cmd_t              cmd
);

    // Decode the address bit and the word-type field into strobes.
    always_comb begin
        cmd         = '0;
        cmd.eoi_cmd = CMD_NONE;
        cmd.eoi_lvl = wr_data[LVL_W-1:0];
        cmd.mask_val = wr_data;
        if (wr_en) begin
            if (reg_sel) begin
                cmd.mask_we = 1'b1;
            end else if (wr_data[4:3] == 2'b00) begin
                unique case (wr_data[7:5])
                    3'b001:  cmd.eoi_cmd = CMD_EOI_NS;
                    3'b011:  cmd.eoi_cmd = CMD_EOI_SP;
                    3'b101:  cmd.eoi_cmd = CMD_ROT_NS;
                    3'b111:  cmd.eoi_cmd = CMD_ROT_SP;
                    3'b110:  cmd.eoi_cmd = CMD_SET_PRI;
                    default: cmd.eoi_cmd = CMD_NONE;
                endcase
            end else if (wr_data[4:3] == 2'b01 && !wr_data[7]) begin
                cmd.mode_we  = 1'b1;
                cmd.smm_we   = wr_data[6];
                cmd.smm_val  = wr_data[5];
                cmd.rsel_we  = wr_data[1];
                cmd.rsel_val = wr_data[0];
            end
        end
    end

endmodule

// File: rtl/pic8_resolver.sv
// Module: pic8_resolver
// Combinational priority resolver. It finds the highest in-service level,
// decides per level whether a pending unmasked request may interrupt, and
// picks the winner under the rotating order. Assumes low names the current
// lowest-priority level.
module pic8_resolver
    import pic8_pkg::*;
(
    input  logic [NUM_LVL-1:0] req,
    input  logic [NUM_LVL-1:0] mask,
    input  logic [NUM_LVL-1:0] insvc,
    input  lvl_t               low,
    input  logic               smm,
    output logic [NUM_LVL-1:0] cand,
    output logic               irq,
    output logic               win_found,
    output lvl_t               win_lvl,
    output logic               is_found,
    output lvl_t               is_lvl
);

    lvl_t is_rank;

    // Locate the in-service level of highest priority.
    assign {is_found, is_lvl} = pick_top(insvc, low);
    assign is_rank            = rank_of(is_lvl, low);

    // Per-level qualification: normal mode nests on the top in-service level,
    // special mask mode lets each level block only itself.
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        logic above_top;
        logic blocked;
        assign above_top = !is_found || (rank_of(lvl_t'(g), low) < is_rank);
        assign blocked   = smm ? insvc[g] : !above_top;
        assign cand[g]   = req[g] & ~mask[g] & ~blocked;
    end

    // Winner among qualified requests, and the interrupt output.
    assign {win_found, win_lvl} = pick_top(cand, low);
    assign irq                  = |cand;

endmodule

// File: rtl/pic8_ack_seq.sv
// Module: pic8_ack_seq
// Two-pulse acknowledge sequencer. The first pulse captures the winner and
// asks for its in-service bit to be set. The second pulse registers the vector
// and, when automatic end of interrupt is on, asks for that bit to be cleared.
// Assumes each ack pulse lasts one cycle.
module pic8_ack_seq
    import pic8_pkg::*;
#(
    parameter logic [BASE_W-1:0] VEC_BASE = 5'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack,
    input  logic              win_found,
    input  lvl_t              win_lvl,
    input  logic              auto_eoi_en,
    output logic              set_in,
    output lvl_t              set_lvl,
    output logic              aeoi_clr,
    output lvl_t              aeoi_lvl,
    output logic              vec_valid,
    output logic [DATA_W-1:0] vec_out
);

    localparam lvl_t SPUR_LVL = lvl_t'(NUM_LVL - 1);

    logic phase_q;
    lvl_t held_lvl_q;
    logic held_real_q;

    // Requests toward the in-service register.
    assign set_in   = ack && !phase_q && win_found;
    assign set_lvl  = win_lvl;
    assign aeoi_clr = ack && phase_q && held_real_q && auto_eoi_en;
    assign aeoi_lvl = held_lvl_q;

    // Track the phase and hold the captured level between the two pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= 1'b0;
            held_lvl_q  <= '0;
            held_real_q <= 1'b0;
        end else if (ack) begin
            phase_q <= !phase_q;
            if (!phase_q) begin
                held_lvl_q  <= win_found ? win_lvl : SPUR_LVL;
                held_real_q <= win_found;
            end
        end
    end

    // Register the vector and its one-cycle strobe on the second pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            vec_valid <= ack && phase_q;
            if (ack && phase_q) begin
                vec_out <= {VEC_BASE, held_lvl_q};
            end
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) vec_valid |=> !vec_valid); // R4
    AST_SPURIOUS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) (ack && !phase_q && !win_found) |=> (held_lvl_q == SPUR_LVL && !held_real_q)); // R13
    AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n) vec_valid |-> (vec_out[DATA_W-1:LVL_W] == VEC_BASE)); // R4

endmodule

// File: rtl/pic8_core.sv
// Module: pic8_core
// Top of the eight-input priority interrupt controller. Holds the request,
// mask and in-service registers, the lowest-priority pointer, the mask mode
// and the read-source selection, and ties together the decoder, resolver and
// acknowledge sequencer. Assumes reset defaults replace any initialisation.
module pic8_core
    import pic8_pkg::*;
#(
    parameter logic [BASE_W-1:0] VEC_BASE = 5'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NUM_LVL-1:0] irq_in,
    input  logic              auto_eoi_en,
    input  logic              ack,
    output logic              irq_out,
    output logic              vec_valid,
    output logic [DATA_W-1:0] vec_out
);

    localparam lvl_t RESET_LOW = lvl_t'(NUM_LVL - 1);

    cmd_t               cmd;
    logic [NUM_LVL-1:0] req_q;
    logic [NUM_LVL-1:0] mask_q;
    logic [NUM_LVL-1:0] insvc_q;
    logic [NUM_LVL-1:0] insvc_nxt;
    lvl_t               low_q;
    lvl_t               low_nxt;
    logic               smm_q;
    logic               rsel_is_q;
    logic [NUM_LVL-1:0] cand;
    logic               win_found;
    lvl_t               win_lvl;
    logic               is_found;
    lvl_t               is_lvl;
    logic               set_in;
    lvl_t               set_lvl;
    logic               aeoi_clr;
    lvl_t               aeoi_lvl;

    pic8_cmd_decode u_dec (
        .wr_en   (wr_en),
        .reg_sel (reg_sel),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    pic8_resolver u_res (
        .req       (req_q),
        .mask      (mask_q),
        .insvc     (insvc_q),
        .low       (low_q),
        .smm       (smm_q),
        .cand      (cand),
        .irq       (irq_out),
        .win_found (win_found),
        .win_lvl   (win_lvl),
        .is_found  (is_found),
        .is_lvl    (is_lvl)
    );

    pic8_ack_seq #(.VEC_BASE(VEC_BASE)) u_ack (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack         (ack),
        .win_found   (win_found),
        .win_lvl     (win_lvl),
        .auto_eoi_en (auto_eoi_en),
        .set_in      (set_in),
        .set_lvl     (set_lvl),
        .aeoi_clr    (aeoi_clr),
        .aeoi_lvl    (aeoi_lvl),
        .vec_valid   (vec_valid),
        .vec_out     (vec_out)
    );

    // Sample the request lines every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= irq_in;
    end

    // Mask register, written only by the mask word.
    always_ff @(posedge clk) begin
        if (!rst_n)           mask_q <= '0;
        else if (cmd.mask_we) mask_q <= cmd.mask_val;
    end

    // Mask mode and read source, written by the mode word under their enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smm_q     <= 1'b0;
            rsel_is_q <= 1'b0;
        end else begin
            if (cmd.smm_we)  smm_q     <= cmd.smm_val;
            if (cmd.rsel_we) rsel_is_q <= cmd.rsel_val;
        end
    end

    // Next in-service state: command clears, then auto clear, then ack set.
    always_comb begin
        insvc_nxt = insvc_q;
        unique case (cmd.eoi_cmd)
            CMD_EOI_NS, CMD_ROT_NS: if (is_found) insvc_nxt[is_lvl] = 1'b0;
            CMD_EOI_SP, CMD_ROT_SP: insvc_nxt[cmd.eoi_lvl] = 1'b0;
            default: ;
        endcase
        if (aeoi_clr) insvc_nxt[aeoi_lvl] = 1'b0;
        if (set_in)   insvc_nxt[set_lvl]  = 1'b1;
    end

    // Next lowest-priority level from rotate and set-priority commands.
    always_comb begin
        low_nxt = low_q;
        unique case (cmd.eoi_cmd)
            CMD_ROT_NS:              if (is_found) low_nxt = is_lvl;
            CMD_ROT_SP, CMD_SET_PRI: low_nxt = cmd.eoi_lvl;
            default: ;
        endcase
    end

    // In-service register and priority pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            insvc_q <= '0;
            low_q   <= RESET_LOW;
        end else begin
            insvc_q <= insvc_nxt;
            low_q   <= low_nxt;
        end
    end

    // Read mux: mask at address 1, otherwise the selected source.
    always_comb begin
        if (reg_sel)        rd_data = mask_q;
        else if (rsel_is_q) rd_data = insvc_q;
        else                rd_data = req_q;
    end

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && reg_sel) |=> (mask_q == $past(wr_data))); // R1
    AST_WIN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n) win_found |-> (req_q[win_lvl] && !mask_q[win_lvl])); // R3
    AST_IRQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) irq_out |-> (|(req_q & ~mask_q))); // R3
    AST_ACK_SETS: assert property (@(posedge clk) disable iff (!rst_n) set_in |=> insvc_q[$past(set_lvl)]); // R4
    AST_NESTED_ORDER: assert property (@(posedge clk) disable iff (!rst_n) (!smm_q && win_found && is_found) |-> (rank_of(win_lvl, low_q) < rank_of(is_lvl, low_q))); // R5
    AST_SPEC_EOI: assert property (@(posedge clk) disable iff (!rst_n) (cmd.eoi_cmd == CMD_EOI_SP && !set_in) |=> !insvc_q[$past(cmd.eoi_lvl)]); // R7
    AST_ROT_SP_LOW: assert property (@(posedge clk) disable iff (!rst_n) (cmd.eoi_cmd == CMD_ROT_SP) |=> (low_q == $past(cmd.eoi_lvl))); // R8
    AST_SETPRI_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (cmd.eoi_cmd == CMD_SET_PRI && !set_in && !aeoi_clr) |=> $stable(insvc_q)); // R9
    AST_SMM_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cmd.mode_we && !cmd.smm_we) |=> $stable(smm_q)); // R10
    AST_SMM_SELF_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) (smm_q && win_found) |-> !insvc_q[win_lvl]); // R10
    AST_AUTO_EOI: assert property (@(posedge clk) disable iff (!rst_n) aeoi_clr |=> !insvc_q[$past(aeoi_lvl)]); // R11
    AST_BAD_WORD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !reg_sel && wr_data[4]) |=> ($stable(mask_q) && $stable(low_q) && $stable(smm_q) && $stable(rsel_is_q))); // R14

endmodule

// File: tb/pic8_core_tb_top.sv
// Scoreboard bench: the acknowledge driver queues expected vectors and a
// monitor pops and compares them when vec_valid appears.
module pic8_core_tb_top;

    localparam int         CLK_PERIOD = 10;
    localparam logic [4:0] BASE       = 5'h08;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] irq_in = '0;
    logic       auto_eoi_en = 1'b0;
    logic       ack = 1'b0;
    logic       irq_out;
    logic       vec_valid;
    logic [7:0] vec_out;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       prev_valid = 1'b0;

    pic8_core #(.VEC_BASE(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq_in(irq_in),
        .auto_eoi_en(auto_eoi_en), .ack(ack), .irq_out(irq_out),
        .vec_valid(vec_valid), .vec_out(vec_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_sel = a; wr_data = d; wr_en = 1'b1;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic a, input logic [7:0] exp);
        reg_sel = a;
        #1;
        check8(tag, rd_data, exp);
    endtask

    task automatic irq_check(input string tag, input logic exp);
        check8(tag, {7'b0, irq_out}, {7'b0, exp});
    endtask

    // Driver: two ack pulses, expected vector queued before the second.
    task automatic ack_seq(input logic [2:0] lvl, input string tag);
        ack = 1'b1; step(1); ack = 1'b0; step(1);
        exp_q.push_back({BASE, lvl});
        tag_q.push_back(tag);
        ack = 1'b1; step(1); ack = 1'b0; step(1);
    endtask

    task automatic set_irq(input logic [7:0] v);
        irq_in = v; step(2);
    endtask

    // Monitor: compare vectors as they appear and check the strobe width.
    always @(negedge clk) begin
        if (rst_n) begin
            if (vec_valid && prev_valid) begin
                n_cmp++; n_bad++;
                $display("FAIL R4 strobe: actual 2 cycles expected 1");
            end
            if (vec_valid) begin
                if (exp_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R4 unexpected vector: actual %02h expected none", vec_out);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check8(t, vec_out, e);
                end
            end
        end
        prev_valid = vec_valid;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R2 reset state
        irq_check("R2 irq_out after reset", 1'b0);
        check8("R2 vec_valid after reset", {7'b0, vec_valid}, 8'h00);
        rd_check("R2 mask after reset", 1'b1, 8'h00);
        rd_check("R2 read source after reset", 1'b0, 8'h00);

        // R1 mask write and read back
        wr(1'b1, 8'hA5);
        rd_check("R1 mask readback", 1'b1, 8'hA5);
        set_irq(8'h21);
        irq_check("R1 masked levels only", 1'b0);
        set_irq(8'h00);
        wr(1'b1, 8'h00);

        // R3 fixed order, R4 ack sets in-service
        set_irq(8'h34);
        irq_check("R3 irq_out on request", 1'b1);
        ack_seq(3'd2, "R3 lowest index wins");
        wr(1'b0, 8'h0B);
        rd_check("R4 in-service after ack", 1'b0, 8'h04);

        // R5 nesting
        irq_check("R5 lower levels held off", 1'b0);
        set_irq(8'h36);
        irq_check("R5 higher level raises irq", 1'b1);
        ack_seq(3'd1, "R5 higher level vector");
        rd_check("R5 nested in-service", 1'b0, 8'h06);
        set_irq(8'h00);

        // R6 and R7
        wr(1'b0, 8'h20);
        rd_check("R6 non-specific clears top", 1'b0, 8'h04);
        wr(1'b0, 8'h62);
        rd_check("R7 specific clears level 2", 1'b0, 8'h00);

        // R12 read source selection
        wr(1'b0, 8'h0A);
        set_irq(8'h81);
        rd_check("R12 request source", 1'b0, 8'h81);
        wr(1'b0, 8'h0B);
        rd_check("R12 in-service source", 1'b0, 8'h00);
        wr(1'b0, 8'h08);
        rd_check("R12 RR=0 keeps selection", 1'b0, 8'h00);
        set_irq(8'h00);

        // R13 nothing qualifies
        wr(1'b1, 8'hFF);
        set_irq(8'h01);
        ack_seq(3'd7, "R13 spurious vector");
        rd_check("R13 no in-service bit", 1'b0, 8'h00);
        wr(1'b1, 8'h00);
        set_irq(8'h00);

        // R8 rotate on non-specific EOI
        set_irq(8'h01);
        ack_seq(3'd0, "R8 level 0 first");
        wr(1'b0, 8'hA0);
        rd_check("R8 rotate clears level 0", 1'b0, 8'h00);
        set_irq(8'h03);
        ack_seq(3'd1, "R8 level 0 now lowest");
        wr(1'b0, 8'h20);
        set_irq(8'h00);

        // R9 set priority
        wr(1'b0, 8'hC4);
        set_irq(8'h90);
        ack_seq(3'd7, "R9 level 7 beats level 4");
        rd_check("R9 in-service level 7", 1'b0, 8'h80);
        wr(1'b0, 8'hC1);
        rd_check("R9 set priority keeps in-service", 1'b0, 8'h80);
        wr(1'b0, 8'h67);
        set_irq(8'h00);

        // R8 rotate on specific EOI
        wr(1'b0, 8'hC4);
        set_irq(8'h09);
        ack_seq(3'd0, "R8 level 0 before 3");
        wr(1'b0, 8'hE0);
        ack_seq(3'd3, "R8 specific rotate makes 0 lowest");
        wr(1'b0, 8'h20);
        rd_check("R8 in-service empty", 1'b0, 8'h00);
        set_irq(8'h00);
        wr(1'b0, 8'hC7);

        // R10 special mask mode
        set_irq(8'h01);
        ack_seq(3'd0, "R10 level 0 in service");
        set_irq(8'h05);
        irq_check("R5 normal mode blocks level 2", 1'b0);
        wr(1'b0, 8'h68);
        irq_check("R10 special mode frees level 2", 1'b1);
        ack_seq(3'd2, "R10 level 2 under level 0");
        rd_check("R10 in-service 0 and 2", 1'b0, 8'h05);
        set_irq(8'h15);
        wr(1'b0, 8'h28);
        irq_check("R10 ESMM=0 keeps special mode", 1'b1);
        wr(1'b0, 8'h48);
        irq_check("R10 back to normal mode", 1'b0);
        set_irq(8'h00);
        wr(1'b0, 8'h60);
        wr(1'b0, 8'h62);
        rd_check("R10 in-service cleared", 1'b0, 8'h00);

        // R14 invalid words
        wr(1'b0, 8'h0A);
        set_irq(8'h40);
        wr(1'b0, 8'h13);
        rd_check("R14 bit4 word ignored", 1'b0, 8'h40);
        wr(1'b0, 8'h8B);
        rd_check("R14 bit7 mode word ignored", 1'b0, 8'h40);
        rd_check("R14 mask unchanged", 1'b1, 8'h00);

        // R11 automatic end of interrupt
        auto_eoi_en = 1'b1;
        ack_seq(3'd6, "R11 vector level 6");
        wr(1'b0, 8'h0B);
        rd_check("R11 auto clear", 1'b0, 8'h00);
        auto_eoi_en = 1'b0;
        set_irq(8'h00);

        step(3);
        check8("R4 all vectors seen", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule